// File: doc/BRIEF.md
# Timer Status and Interrupt Register Unit

This block is the register front end for a bank of identical timers. It sits on a simple single-cycle bus made of a strobe, a write enable, a word address, per-byte lane selects and 32-bit write data. The address picks a timer and then one of that timer's eight registers. The block holds each timer's configuration values (control, counter load value, prescaler, reload value and two compare values) and drives them out continuously to the counter cores. It also holds a small set of event flags and their interrupt enables.

The counter cores and channels report events as one-cycle pulses. Each pulse latches the matching flag. Software removes a flag by writing a zero to its bit position, and a one in the same write leaves the flag alone. Each timer raises its own interrupt line while any flag is pending whose enable bit is also set. The counting, prescaling and waveform logic live elsewhere.

Top module: `tmr_status_regs`

## Requirements
- R1: The word address `bus_addr_i` splits into a timer index (upper bits) and a register select in bits [2:0], with the encoding 0 control, 1 counter value, 2 prescaler, 3 reload, 4 compare 0, 5 compare 1, 6 status, 7 interrupt enable. A write changes only the addressed register of the addressed timer.
- R2: A read (strobe high, write enable low) places the addressed register on `bus_rdata_o` from the next rising clock edge. The value then holds until the next read.
- R3: For the control, counter, prescaler, reload, compare and enable registers, `bus_be_i[i]` enables write data byte i (bits 8i+7..8i). Unselected bytes keep their old value.
- R4: The control register is 8 bits wide and the prescaler is 16 bits wide. The enable register implements bits 0, 2, 3 and 4. All other bits read as zero, and write data aimed at them is ignored.
- R5: The status word has these bits: bit 0 update flag, bit 1 the live `dir_i` level of that timer (read-only), bit 2 trigger flag, bit 3 channel 0 flag, bit 4 channel 1 flag. All other bits read as zero.
- R6: A one-cycle pulse on `upd_set_i`, `trg_set_i`, `cc0_set_i` or `cc1_set_i` sets the matching flag at that clock edge.
- R7: A status write clears each flag whose write-data bit is 0, and leaves each flag whose bit is 1 unchanged. Status writes ignore the byte selects.
- R8: When a set pulse and a clearing status write hit the same flag in the same cycle, the flag ends up set.
- R9: `irq_o[n]` is high exactly while the bitwise AND of timer n's status flags and its enable register is nonzero. It therefore rises one clock after a set pulse for an enabled flag.
- R10: After reset, every register, every flag, `bus_rdata_o` and every `irq_o` bit is zero.
- R11: Each timer's control, counter, prescaler, reload and compare values appear on the matching output slices at all times, in timer order with timer 0 in the lowest slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_stb_i | input | 1 | Bus access strobe |
| bus_addr_i | input | $clog2(NUM_TIMERS)+3 | Word address: timer index and register select |
| bus_be_i | input | 4 | Byte lane selects |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| upd_set_i | input | NUM_TIMERS | Update event pulses, one per timer |
| trg_set_i | input | NUM_TIMERS | Trigger event pulses |
| cc0_set_i | input | NUM_TIMERS | Channel 0 event pulses |
| cc1_set_i | input | NUM_TIMERS | Channel 1 event pulses |
| dir_i | input | NUM_TIMERS | Live count direction from each core |
| ctrl_o | output | NUM_TIMERS*8 | Control values |
| cnt_o | output | NUM_TIMERS*32 | Counter values |
| psc_o | output | NUM_TIMERS*16 | Prescaler values |
| arr_o | output | NUM_TIMERS*32 | Reload values |
| ccr0_o | output | NUM_TIMERS*32 | Compare 0 values |
| ccr1_o | output | NUM_TIMERS*32 | Compare 1 values |
| irq_o | output | NUM_TIMERS | Interrupt line per timer |

## Verification
A hardware set pulse and a software clear can land on the same flag in the same cycle, and the outcome must favour the set. The bench forces this directly by pulsing the update event while writing an all-zero status word. Random traffic also produces it, because event pulses arrive freely during status writes. A bench model applies set-over-clear to every flag, and each status read-back and every interrupt line is compared against that model.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;

    localparam int BUS_W     = 32;
    localparam int BUS_BYTES = BUS_W / 8;
    localparam int CTRL_W    = 8;
    localparam int PSC_W     = 16;
    localparam int FLAG_W    = 5;

    localparam int FLG_UPD = 0;
    localparam int FLG_DIR = 1;
    localparam int FLG_TRG = 2;
    localparam int FLG_CH0 = 3;
    localparam int FLG_CH1 = 4;

    localparam logic [FLAG_W-1:0] FLAG_MASK = 5'b11101;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_CNT  = 3'd1,
        REG_PSC  = 3'd2,
        REG_ARR  = 3'd3,
        REG_CCR0 = 3'd4,
        REG_CCR1 = 3'd5,
        REG_STAT = 3'd6,
        REG_IEN  = 3'd7
    } reg_sel_e;

    function automatic logic [BUS_W-1:0] merge_bytes(
        input logic [BUS_W-1:0]     old_v,
        input logic [BUS_W-1:0]     new_v,
        input logic [BUS_BYTES-1:0] be
    );
        logic [BUS_W-1:0] res;
        for (int i = 0; i < BUS_BYTES; i++) begin
            res[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/tmr_reg_slice.sv
module tmr_reg_slice
    import tmr_regs_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  reg_sel_e             sel_i,
    input  logic [BUS_BYTES-1:0] be_i,
    input  logic [BUS_W-1:0]     wdata_i,
    input  logic [FLAG_W-1:0]    set_i,
    input  logic                 dir_i,
    output logic [CTRL_W-1:0]    ctrl_o,
    output logic [BUS_W-1:0]     cnt_o,
    output logic [PSC_W-1:0]     psc_o,
    output logic [BUS_W-1:0]     arr_o,
    output logic [BUS_W-1:0]     ccr0_o,
    output logic [BUS_W-1:0]     ccr1_o,
    output logic [BUS_W-1:0]     rword_o,
    output logic                 irq_o
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [BUS_W-1:0]  cnt;
        logic [PSC_W-1:0]  psc;
        logic [BUS_W-1:0]  arr;
        logic [BUS_W-1:0]  ccr0;
        logic [BUS_W-1:0]  ccr1;
        logic [FLAG_W-1:0] stat;
        logic [FLAG_W-1:0] ien;
    } slice_state_t;

    slice_state_t st_d, st_q;
    logic [BUS_W-1:0]  ctrl_m_d, psc_m_d, ien_m_d;
    logic [FLAG_W-1:0] clr_d;

    always_comb begin
        st_d     = st_q;
        ctrl_m_d = merge_bytes(BUS_W'(st_q.ctrl), wdata_i, be_i);
        psc_m_d  = merge_bytes(BUS_W'(st_q.psc), wdata_i, be_i);
        ien_m_d  = merge_bytes(BUS_W'(st_q.ien), wdata_i, be_i);
        if (wr_i) begin
            case (sel_i)
                REG_CTRL: st_d.ctrl = ctrl_m_d[CTRL_W-1:0];
                REG_CNT:  st_d.cnt  = merge_bytes(st_q.cnt, wdata_i, be_i);
                REG_PSC:  st_d.psc  = psc_m_d[PSC_W-1:0];
                REG_ARR:  st_d.arr  = merge_bytes(st_q.arr, wdata_i, be_i);
                REG_CCR0: st_d.ccr0 = merge_bytes(st_q.ccr0, wdata_i, be_i);
                REG_CCR1: st_d.ccr1 = merge_bytes(st_q.ccr1, wdata_i, be_i);
                REG_IEN:  st_d.ien  = ien_m_d[FLAG_W-1:0] & FLAG_MASK;
                default:  ;
            endcase
        end
        clr_d     = (wr_i && sel_i == REG_STAT) ? (~wdata_i[FLAG_W-1:0] & FLAG_MASK) : '0;
        st_d.stat = (set_i & FLAG_MASK) | (st_q.stat & ~clr_d & FLAG_MASK);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        case (sel_i)
            REG_CTRL: rword_o = BUS_W'(st_q.ctrl);
            REG_CNT:  rword_o = st_q.cnt;
            REG_PSC:  rword_o = BUS_W'(st_q.psc);
            REG_ARR:  rword_o = st_q.arr;
            REG_CCR0: rword_o = st_q.ccr0;
            REG_CCR1: rword_o = st_q.ccr1;
            REG_STAT: rword_o = BUS_W'(st_q.stat | (FLAG_W'(dir_i) << FLG_DIR));
            default:  rword_o = BUS_W'(st_q.ien);
        endcase
    end

    assign ctrl_o = st_q.ctrl;
    assign cnt_o  = st_q.cnt;
    assign psc_o  = st_q.psc;
    assign arr_o  = st_q.arr;
    assign ccr0_o = st_q.ccr0;
    assign ccr1_o = st_q.ccr1;
    assign irq_o  = |(st_q.stat & st_q.ien);

    // R6 R8
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i & FLAG_MASK) != '0 |=>
        ((st_q.stat & $past(set_i & FLAG_MASK)) == $past(set_i & FLAG_MASK)));

    // R7
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && sel_i == REG_STAT) |=>
        ((st_q.stat & ~$past(set_i) & ~$past(wdata_i[FLAG_W-1:0])) == '0));

    // R7
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((set_i & FLAG_MASK) == '0 &&
         !(wr_i && sel_i == REG_STAT && (~wdata_i[FLAG_W-1:0] & FLAG_MASK) != '0))
        |=> $stable(st_q.stat));

    // R9
    irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((set_i & st_q.ien & FLAG_MASK) != '0 && !(wr_i && sel_i == REG_IEN))
        |=> irq_o);

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_regs_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    parameter int IDX_W      = 2
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        rd_en_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [NUM_TIMERS*BUS_W-1:0] words_i,
    output logic [BUS_W-1:0]            rdata_o
);

    logic [BUS_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en_i) begin
            rdata_d = '0;
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (32'(idx_i) == t) rdata_d = words_i[t*BUS_W +: BUS_W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdata_q <= '0;
        else         rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

    // R2
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o));

endmodule

// File: rtl/tmr_status_regs.sv
module tmr_status_regs
    import tmr_regs_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    localparam int IDX_W     = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
    localparam int ADDR_W    = IDX_W + 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        bus_stb_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic [BUS_BYTES-1:0]        bus_be_i,
    input  logic                        bus_we_i,
    input  logic [BUS_W-1:0]            bus_wdata_i,
    output logic [BUS_W-1:0]            bus_rdata_o,
    input  logic [NUM_TIMERS-1:0]       upd_set_i,
    input  logic [NUM_TIMERS-1:0]       trg_set_i,
    input  logic [NUM_TIMERS-1:0]       cc0_set_i,
    input  logic [NUM_TIMERS-1:0]       cc1_set_i,
    input  logic [NUM_TIMERS-1:0]       dir_i,
    output logic [NUM_TIMERS*CTRL_W-1:0] ctrl_o,
    output logic [NUM_TIMERS*BUS_W-1:0] cnt_o,
    output logic [NUM_TIMERS*PSC_W-1:0] psc_o,
    output logic [NUM_TIMERS*BUS_W-1:0] arr_o,
    output logic [NUM_TIMERS*BUS_W-1:0] ccr0_o,
    output logic [NUM_TIMERS*BUS_W-1:0] ccr1_o,
    output logic [NUM_TIMERS-1:0]       irq_o
);

    logic [IDX_W-1:0]            idx;
    reg_sel_e                    sel;
    logic                        wr_any;
    logic                        rd_en;
    logic [NUM_TIMERS*BUS_W-1:0] words;

    assign idx    = bus_addr_i[ADDR_W-1:3];
    assign sel    = reg_sel_e'(bus_addr_i[2:0]);
    assign wr_any = bus_stb_i & bus_we_i;
    assign rd_en  = bus_stb_i & ~bus_we_i;

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        logic              wr_t;
        logic [FLAG_W-1:0] set_t;

        assign wr_t  = wr_any && (32'(idx) == t);
        assign set_t = {cc1_set_i[t], cc0_set_i[t], trg_set_i[t], 1'b0, upd_set_i[t]};

        tmr_reg_slice i_slice (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (wr_t),
            .sel_i   (sel),
            .be_i    (bus_be_i),
            .wdata_i (bus_wdata_i),
            .set_i   (set_t),
            .dir_i   (dir_i[t]),
            .ctrl_o  (ctrl_o[t*CTRL_W +: CTRL_W]),
            .cnt_o   (cnt_o[t*BUS_W +: BUS_W]),
            .psc_o   (psc_o[t*PSC_W +: PSC_W]),
            .arr_o   (arr_o[t*BUS_W +: BUS_W]),
            .ccr0_o  (ccr0_o[t*BUS_W +: BUS_W]),
            .ccr1_o  (ccr1_o[t*BUS_W +: BUS_W]),
            .rword_o (words[t*BUS_W +: BUS_W]),
            .irq_o   (irq_o[t])
        );
    end

    tmr_rd_mux #(
        .NUM_TIMERS (NUM_TIMERS),
        .IDX_W      (IDX_W)
    ) i_rd_mux (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_en_i (rd_en),
        .idx_i   (idx),
        .words_i (words),
        .rdata_o (bus_rdata_o)
    );

endmodule

// File: tb/test_tmr_status_regs.sv
module test_tmr_status_regs;

    localparam int NT = 4;
    localparam int AW = $clog2(NT) + 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            stb, we;
    logic [AW-1:0]   addr;
    logic [3:0]      be;
    logic [31:0]     wdata;
    logic [31:0]     rdata;
    logic [NT-1:0]   upd, trg, c0, c1, dir, irq;
    logic [NT*8-1:0]  ctrl_o;
    logic [NT*32-1:0] cnt_o, arr_o, ccr0_o, ccr1_o;
    logic [NT*16-1:0] psc_o;

    always #10 clk = ~clk;

    tmr_status_regs #(.NUM_TIMERS(NT)) i_tmr_status_regs (
        .clk_i(clk), .rst_ni(rst_n), .bus_stb_i(stb), .bus_addr_i(addr),
        .bus_be_i(be), .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .upd_set_i(upd), .trg_set_i(trg), .cc0_set_i(c0), .cc1_set_i(c1),
        .dir_i(dir), .ctrl_o(ctrl_o), .cnt_o(cnt_o), .psc_o(psc_o),
        .arr_o(arr_o), .ccr0_o(ccr0_o), .ccr1_o(ccr1_o), .irq_o(irq)
    );

    int tests = 0;
    int fails = 0;
    logic [31:0] m_reg [NT][8];
    logic [31:0] last_rd = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] b);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = b[i] ? n[i*8 +: 8] : o[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] reg_mask(input int r);
        case (r)
            0:       return 32'h0000_00FF;
            2:       return 32'h0000_FFFF;
            6, 7:    return 32'h0000_001D;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input int t, input int r, input logic d);
        if (r == 6) return m_reg[t][6] | (32'(d) << 1);
        return m_reg[t][r];
    endfunction

    task automatic op(input bit s, input bit w, input int t, input int r, input logic [3:0] b,
                      input logic [31:0] wd, input logic [NT-1:0] u, input logic [NT-1:0] tg,
                      input logic [NT-1:0] a0, input logic [NT-1:0] a1, input logic [NT-1:0] dr,
                      input string tag);
        logic [31:0] exp_rd;
        string rtag;
        stb = s; we = w; addr = AW'((t << 3) | r); be = b; wdata = wd;
        upd = u; trg = tg; c0 = a0; c1 = a1; dir = dr;
        exp_rd = exp_read(t, r, dr[t]);
        @(posedge clk);
        for (int tt = 0; tt < NT; tt++) begin
            logic [31:0] setv, clr, sr;
            sr   = m_reg[tt][6];
            setv = {27'd0, a1[tt], a0[tt], tg[tt], 1'b0, u[tt]};
            clr  = (s && w && tt == t && r == 6) ? (~wd & 32'h1D) : 32'd0;
            if (s && w && tt == t && r != 6)
                m_reg[tt][r] = lane_merge(m_reg[tt][r], wd, b) & reg_mask(r);
            m_reg[tt][6] = setv | (sr & ~clr);
        end
        @(negedge clk);
        if (s && !w) begin
            if (tag != "") rtag = tag;
            else if (r == 6) rtag = "R5 status read";
            else if (r == 2 || r == 0 || r == 7) rtag = "R4 narrow register read";
            else rtag = "R1 R3 register read";
            chk(rtag, rdata, exp_rd);
            last_rd = exp_rd;
        end else begin
            chk("R2 read data hold", rdata, last_rd);
        end
        for (int tt = 0; tt < NT; tt++)
            chk("R9 irq", 32'(irq[tt]), 32'(|(m_reg[tt][6] & m_reg[tt][7])));
        stb = 0; we = 0; upd = '0; trg = '0; c0 = '0; c1 = '0;
    endtask

    task automatic check_ports();
        for (int tt = 0; tt < NT; tt++) begin
            chk("R11 ctrl_o", 32'(ctrl_o[tt*8 +: 8]), m_reg[tt][0]);
            chk("R11 cnt_o",  cnt_o[tt*32 +: 32], m_reg[tt][1]);
            chk("R11 psc_o",  32'(psc_o[tt*16 +: 16]), m_reg[tt][2]);
            chk("R11 arr_o",  arr_o[tt*32 +: 32], m_reg[tt][3]);
            chk("R11 ccr0_o", ccr0_o[tt*32 +: 32], m_reg[tt][4]);
            chk("R11 ccr1_o", ccr1_o[tt*32 +: 32], m_reg[tt][5]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int t = 0; t < NT; t++)
            for (int r = 0; r < 8; r++) m_reg[t][r] = '0;
        rst_n = 0; stb = 0; we = 0; addr = '0; be = '0; wdata = '0;
        upd = '0; trg = '0; c0 = '0; c1 = '0; dir = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rdata after reset", rdata, 32'd0);
        chk("R10 irq after reset", 32'(irq), 32'd0);
        check_ports();
        for (int r = 0; r < 8; r++) op(1, 0, 0, r, 4'h0, '0, '0, '0, '0, '0, '0, "R10 register after reset");

        // R4 width limits
        op(1, 1, 1, 2, 4'hF, 32'hFFFF_FFFF, '0, '0, '0, '0, '0, "");
        op(1, 0, 1, 2, 4'h0, '0, '0, '0, '0, '0, '0, "R4 prescaler width");
        chk("R4 prescaler literal", rdata, 32'h0000_FFFF);
        op(1, 1, 1, 0, 4'hF, 32'hFFFF_FFFF, '0, '0, '0, '0, '0, "");
        op(1, 0, 1, 0, 4'h0, '0, '0, '0, '0, '0, '0, "R4 control width");
        chk("R4 control literal", rdata, 32'h0000_00FF);
        op(1, 1, 1, 7, 4'hF, 32'hFFFF_FFFF, '0, '0, '0, '0, '0, "");
        op(1, 0, 1, 7, 4'h0, '0, '0, '0, '0, '0, '0, "R4 enable width");
        chk("R4 enable literal", rdata, 32'h0000_001D);

        // R3 byte lanes
        op(1, 1, 2, 1, 4'b0101, 32'hAABB_CCDD, '0, '0, '0, '0, '0, "");
        op(1, 0, 2, 1, 4'h0, '0, '0, '0, '0, '0, '0, "R3 byte lanes");
        chk("R3 byte lane literal", rdata, 32'h00BB_00DD);

        // R6 set, R5 dir bit, R7 write one / zero with no byte select
        op(0, 0, 0, 0, 4'h0, '0, 4'b0100, '0, '0, '0, '0, "");
        op(1, 0, 2, 6, 4'h0, '0, '0, '0, '0, '0, 4'b0100, "R6 set pulse");
        chk("R5 R6 status literal", rdata, 32'h0000_0003);
        op(1, 1, 2, 6, 4'h0, 32'hFFFF_FFFF, '0, '0, '0, '0, '0, "");
        op(1, 0, 2, 6, 4'h0, '0, '0, '0, '0, '0, '0, "R7 write one keeps flag");
        chk("R7 keep literal", rdata, 32'h0000_0001);
        op(1, 1, 2, 6, 4'h0, 32'h0, '0, '0, '0, '0, '0, "");
        op(1, 0, 2, 6, 4'h0, '0, '0, '0, '0, '0, '0, "R7 write zero clears");
        chk("R7 clear literal", rdata, 32'h0);

        // R8 set wins over clear
        op(1, 1, 3, 6, 4'hF, 32'h0, 4'b1000, '0, 4'b1000, '0, '0, "");
        op(1, 0, 3, 6, 4'h0, '0, '0, '0, '0, '0, '0, "R8 set wins");
        chk("R8 set wins literal", rdata, 32'h0000_0009);

        // R9 irq follows enable
        op(1, 1, 3, 7, 4'hF, 32'h0000_0008, '0, '0, '0, '0, '0, "");
        chk("R9 irq enabled flag", 32'(irq[3]), 32'd1);
        op(1, 1, 3, 7, 4'hF, 32'h0000_0004, '0, '0, '0, '0, '0, "");
        chk("R9 irq masked flag", 32'(irq[3]), 32'd0);
        check_ports();

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int kind, t, r;
            logic [NT-1:0] u, tg, a0, a1;
            kind = int'($urandom_range(0, 9));
            t    = int'($urandom_range(0, NT - 1));
            r    = int'($urandom_range(0, 7));
            u  = NT'($urandom) & NT'($urandom) & NT'($urandom);
            tg = NT'($urandom) & NT'($urandom) & NT'($urandom);
            a0 = NT'($urandom) & NT'($urandom) & NT'($urandom);
            a1 = NT'($urandom) & NT'($urandom) & NT'($urandom);
            if (kind < 4)
                op(1, 1, t, r, 4'($urandom), $urandom, u, tg, a0, a1, NT'($urandom), "");
            else if (kind < 8)
                op(1, 0, t, r, 4'($urandom), $urandom, u, tg, a0, a1, NT'($urandom), "");
            else
                op(0, 0, t, r, 4'($urandom), $urandom, u, tg, a0, a1, NT'($urandom), "");
            if (n % 64 == 0) check_ports();
        end
        check_ports();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule